// File: doc/BRIEF.md
# Block Fetch Responder for Cache Refills

This block stands in for main memory behind a cache. On a refill request it takes the block number, spends the bus cycles that a real memory of the chosen organization would spend, and hands the words of the block back on a block-wide lane bus with one valid flag per word lane. All timing is in cycles of the clock that reaches the block, which is the slow bus clock and not the processor clock.

The parameter `ORG` picks one of three memory organizations. The narrow organization is one word wide and runs one access and one transfer per word. The wide organization is one block wide: it makes a single access and moves the whole block in one transfer. The interleaved organization has one bank per word: all banks are accessed together and the words then come out one per cycle. Memory contents are not stored. They are computed from the word address, so a reader can predict every returned word.

The block also measures its own miss penalty. The count runs from the request cycle to the last data cycle, both included, and is held on an output until the next block has fully returned. With the default four-word block and 15-cycle access, the count is 65 for narrow, 17 for wide and 20 for interleaved.

Top module: `blkmem_fetch`

## Requirements
- R1: After reset, `busy` is 0, `word_vld` is all zeros and `miss_pen` is 0.
- R2: A request is taken in a cycle where `req` is 1 and `busy` is 0. That cycle is cycle 0. `busy` is 1 from cycle 1 through the last data cycle L and is 0 in cycle L+1.
- R3: With ORG=0 (narrow), word i is valid by itself in lane i (bit i of `word_vld`) in cycle 16*(i+1). No lane is valid in any other cycle, so L=64.
- R4: With ORG=1 (wide), all four lanes are valid together in cycle 16 and in no other cycle, so L=16.
- R5: With ORG=2 (interleaved), lane i is valid by itself in cycle 16+i. No lane is valid in any other cycle, so L=19.
- R6: Lane i carries bits [32*i+31:32*i] of `blk_data`. Its value is ((4*B+i) * 0x9E3779B1 mod 2^32) XOR 0xA5A50F0F, where B is the block address taken in cycle 0.
- R7: In cycle L+1 `miss_pen` equals L+1, which is 65, 17 or 20 by organization. It keeps that value until the next block's cycle L+1.
- R8: A `req` that arrives while `busy` is 1 has no effect. The block in flight returns the data of its own address, and no further block follows it.
- R9: A request in cycle L+1 of the previous block is taken at once. Its own cycle 0 is that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Block read request, sampled while idle |
| blk_addr | input | ADDR_W | Block address, sampled with an accepted request |
| busy | output | 1 | A block is in flight; requests are ignored |
| word_vld | output | WORDS | Per-lane data valid for the current cycle |
| blk_data | output | WORDS*32 | Word lanes of the block, lane i at bits 32*i and up |
| miss_pen | output | PEN_W | Bus cycles spent by the last completed block |

## Verification
The assertions assume that `req` can be high at any time, including while `busy` is 1. They also assume that `blk_addr` matters only in the accept cycle, and that reset has passed through the internal two-stage release. The bench changes inputs only on falling edges. It raises `req` for exactly one cycle per request, and issues its deliberate overlapping requests only in cycles where `busy` is 1 (in the middle of an access and in the final data cycle). Follow-on requests are issued only in the first idle cycle.

// File: rtl/blkmem_pkg.sv
package blkmem_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [1:0] {
    ORG_NARROW = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_INTLV  = 2'd2
  } org_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_XFER   = 2'd2
  } st_e;

  // Contents of memory as a pure function of the word address.
  function automatic logic [WORD_W-1:0] word_pattern(input logic [31:0] waddr);
    logic [31:0] prod;
    prod = waddr * 32'h9E3779B1;
    return prod ^ 32'hA5A50F0F;
  endfunction

endpackage

// File: rtl/blkmem_seq.sv
module blkmem_seq
  import blkmem_pkg::*;
#(
  parameter org_e        ORG     = ORG_NARROW,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned ACC_LAT = 15,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int unsigned LAT_W  = (ACC_LAT > 1) ? $clog2(ACC_LAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic              accept,
  output logic              busy,
  output logic              last_xfer,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORDS-1:0]  ld_en,
  output logic [WORDS-1:0]  xfer_vld
);

  st_e              st_q, st_d;
  logic [LAT_W-1:0] lat_q, lat_d;
  logic [IDX_W-1:0] widx_q, widx_d;
  logic             ld_fire;

  assign accept = (st_q == ST_IDLE) && req;
  assign busy   = (st_q != ST_IDLE);

  if (ORG == ORG_WIDE) begin : g_last_wide
    assign last_xfer = (st_q == ST_XFER);
  end else begin : g_last_seq
    assign last_xfer = (st_q == ST_XFER) && (widx_q == IDX_W'(WORDS-1));
  end

  // Next-state process
  always_comb begin
    st_d    = st_q;
    lat_d   = lat_q;
    widx_d  = widx_q;
    ld_fire = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req) begin
          st_d   = ST_ACCESS;
          lat_d  = '0;
          widx_d = '0;
        end
      end
      ST_ACCESS: begin
        if (lat_q == LAT_W'(ACC_LAT-1)) begin
          st_d    = ST_XFER;
          ld_fire = 1'b1;
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (last_xfer) begin
          st_d = ST_IDLE;
        end else begin
          widx_d = widx_q + 1'b1;
          if (ORG == ORG_NARROW) begin
            st_d  = ST_ACCESS;
            lat_d = '0;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Per-lane load and transfer strobes, shaped by the organization
  for (genvar i = 0; i < WORDS; i++) begin : g_lane
    if (ORG == ORG_NARROW) begin : g_ld_one
      assign ld_en[i] = ld_fire && (widx_q == IDX_W'(i));
    end else begin : g_ld_all
      assign ld_en[i] = ld_fire;
    end
    if (ORG == ORG_WIDE) begin : g_vld_all
      assign xfer_vld[i] = (st_q == ST_XFER);
    end else begin : g_vld_one
      assign xfer_vld[i] = (st_q == ST_XFER) && (widx_q == IDX_W'(i));
    end
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lat_q  <= '0;
      widx_q <= '0;
      addr_q <= '0;
    end else begin
      st_q   <= st_d;
      lat_q  <= lat_d;
      widx_q <= widx_d;
      if (accept) begin
        addr_q <= blk_addr;
      end
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_xfer) |=> $stable(addr_q));

  if (ORG == ORG_WIDE) begin : g_chk_wide
    p_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_vld != '0) |-> (&xfer_vld));
  end else begin : g_chk_seq
    p_one_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(xfer_vld) <= 1);
  end

  if (ORG == ORG_NARROW) begin : g_chk_gap
    p_access_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((xfer_vld != '0) && !last_xfer) |=> (xfer_vld == '0));
  end

endmodule

// File: rtl/blkmem_bank.sv
module blkmem_bank
  import blkmem_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORDS  = 4,
  parameter int unsigned LANE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] blk_addr,
  output logic [WORD_W-1:0] rdata
);

  logic [31:0]       waddr;
  logic [WORD_W-1:0] data_d;
  logic [WORD_W-1:0] data_q;

  assign waddr = 32'(blk_addr) * 32'(WORDS) + 32'(LANE);

  always_comb begin
    data_d = data_q;
    if (ld) begin
      data_d = word_pattern(waddr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else begin
      data_q <= data_d;
    end
  end

  assign rdata = data_q;

endmodule

// File: rtl/blkmem_pen.sv
module blkmem_pen
  import blkmem_pkg::*;
#(
  parameter org_e        ORG     = ORG_NARROW,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned ACC_LAT = 15,
  parameter int unsigned PEN_W   = 7,
  localparam int unsigned EXP_PEN =
    (ORG == ORG_NARROW) ? 1 + WORDS * (ACC_LAT + 1) :
    (ORG == ORG_WIDE)   ? ACC_LAT + 2 :
                          1 + ACC_LAT + WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             busy,
  input  logic             last_xfer,
  output logic [PEN_W-1:0] pen
);

  logic [PEN_W-1:0] cnt_q, cnt_d;
  logic [PEN_W-1:0] pen_q, pen_d;

  // The request cycle counts as the first cycle of the penalty.
  always_comb begin
    cnt_d = cnt_q;
    pen_d = pen_q;
    if (accept) begin
      cnt_d = PEN_W'(1);
    end else if (busy) begin
      cnt_d = cnt_q + 1'b1;
    end
    if (busy && last_xfer) begin
      pen_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pen_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pen_q <= pen_d;
    end
  end

  assign pen = pen_q;

  p_pen_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && last_xfer) |=> (pen_q == PEN_W'(EXP_PEN)));

endmodule

// File: rtl/blkmem_fetch.sv
module blkmem_fetch
  import blkmem_pkg::*;
#(
  parameter org_e        ORG     = ORG_NARROW,
  parameter int unsigned WORDS   = 4,
  parameter int unsigned ACC_LAT = 15,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned PEN_W  = $clog2(WORDS * (ACC_LAT + 1) + 2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic [ADDR_W-1:0]       blk_addr,
  output logic                    busy,
  output logic [WORDS-1:0]        word_vld,
  output logic [WORDS*WORD_W-1:0] blk_data,
  output logic [PEN_W-1:0]        miss_pen
);

  logic [1:0]        rs_q;
  logic              rst_n_s;
  logic              accept;
  logic              last_xfer;
  logic [ADDR_W-1:0] addr_q;
  logic [WORDS-1:0]  ld_en;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_s = rs_q[1];

  blkmem_seq #(
    .ORG(ORG), .WORDS(WORDS), .ACC_LAT(ACC_LAT), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n_s), .req(req), .blk_addr(blk_addr),
    .accept(accept), .busy(busy), .last_xfer(last_xfer),
    .addr_q(addr_q), .ld_en(ld_en), .xfer_vld(word_vld)
  );

  for (genvar i = 0; i < WORDS; i++) begin : g_bank
    blkmem_bank #(
      .ADDR_W(ADDR_W), .WORDS(WORDS), .LANE(i)
    ) u_bank (
      .clk(clk), .rst_n(rst_n_s), .ld(ld_en[i]), .blk_addr(addr_q),
      .rdata(blk_data[i*WORD_W +: WORD_W])
    );
  end

  blkmem_pen #(
    .ORG(ORG), .WORDS(WORDS), .ACC_LAT(ACC_LAT), .PEN_W(PEN_W)
  ) u_pen (
    .clk(clk), .rst_n(rst_n_s), .accept(accept), .busy(busy),
    .last_xfer(last_xfer), .pen(miss_pen)
  );

  p_vld_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (word_vld != '0) |-> busy);

  p_free_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && last_xfer) |=> !busy);

endmodule

// File: tb/blkmem_fetch_tb.sv
module blkmem_fetch_tb;
  import blkmem_pkg::*;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_m  [3];
  logic [9:0]   addr_m [3];
  logic         busy_m [3];
  logic [3:0]   vld_m  [3];
  logic [127:0] data_m [3];
  logic [6:0]   pen_m  [3];
  int           last_pen [3];
  int           n_chk = 0;
  int           n_bad = 0;

  always #10 clk = ~clk;

  blkmem_fetch #(.ORG(ORG_NARROW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req_m[0]), .blk_addr(addr_m[0]),
    .busy(busy_m[0]), .word_vld(vld_m[0]), .blk_data(data_m[0]), .miss_pen(pen_m[0]));
  blkmem_fetch #(.ORG(ORG_WIDE)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .req(req_m[1]), .blk_addr(addr_m[1]),
    .busy(busy_m[1]), .word_vld(vld_m[1]), .blk_data(data_m[1]), .miss_pen(pen_m[1]));
  blkmem_fetch #(.ORG(ORG_INTLV)) u_dut_il (
    .clk(clk), .rst_n(rst_n), .req(req_m[2]), .blk_addr(addr_m[2]),
    .busy(busy_m[2]), .word_vld(vld_m[2]), .blk_data(data_m[2]), .miss_pen(pen_m[2]));

  task automatic check(input string rq, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [9:0] a, input int i);
    logic [31:0] w;
    w = (32'(a) * 32'd4 + 32'(i)) * 32'h9E3779B1;
    return w ^ 32'hA5A50F0F;
  endfunction

  function automatic int last_cyc(input int m);
    return (m == 0) ? 64 : (m == 1) ? 16 : 19;
  endfunction

  function automatic logic [3:0] exp_vld(input int m, input int k);
    if (m == 0) return (k % 16 == 0 && k >= 16 && k <= 64) ? 4'(1 << (k/16 - 1)) : 4'h0;
    if (m == 1) return (k == 16) ? 4'hF : 4'h0;
    return (k >= 16 && k <= 19) ? 4'(1 << (k - 16)) : 4'h0;
  endfunction

  // One block fetch; called at a falling edge, returns at the falling edge of cycle L+1.
  // intr_k: cycle at whose falling edge an intruding request is raised (0 = none).
  task automatic fetch(input int m, input logic [9:0] a, input int intr_k, input string tag);
    string rq;
    int    L;
    rq = (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
    L  = last_cyc(m);
    req_m[m]  = 1'b1;
    addr_m[m] = a;
    @(negedge clk);
    for (int k = 1; k <= L + 1; k++) begin
      logic [3:0] ev;
      ev = exp_vld(m, k);
      if (k == intr_k) begin
        req_m[m]  = 1'b1;
        addr_m[m] = a ^ 10'h155;
      end else begin
        req_m[m] = 1'b0;
      end
      check(rq, $sformatf("%s word_vld cycle %0d", tag, k), 128'(vld_m[m]), 128'(ev));
      check("R2", $sformatf("%s busy cycle %0d", tag, k), 128'(busy_m[m]), 128'(k <= L));
      for (int i = 0; i < 4; i++) begin
        if (ev[i]) begin
          check("R6", $sformatf("%s lane %0d data", tag, i),
                128'(data_m[m][i*32 +: 32]), 128'(exp_word(a, i)));
        end
      end
      if (k == 1) begin
        check("R7", $sformatf("%s penalty held", tag), 128'(pen_m[m]), 128'(last_pen[m]));
      end
      if (k == L + 1) begin
        check("R7", $sformatf("%s miss penalty", tag), 128'(pen_m[m]), 128'(L + 1));
        last_pen[m] = L + 1;
      end else begin
        @(negedge clk);
      end
    end
    req_m[m] = 1'b0;
  endtask

  task automatic idle_check(input int m, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check("R8", $sformatf("%s no extra block vld", tag), 128'(vld_m[m]), 128'h0);
      check("R8", $sformatf("%s no extra block busy", tag), 128'(busy_m[m]), 128'h0);
    end
  endtask

  task automatic test_reset();
    for (int m = 0; m < 3; m++) begin
      check("R1", "busy after reset", 128'(busy_m[m]), 128'h0);
      check("R1", "word_vld after reset", 128'(vld_m[m]), 128'h0);
      check("R1", "miss_pen after reset", 128'(pen_m[m]), 128'h0);
    end
  endtask

  task automatic test_narrow();
    fetch(0, 10'h000, 0, "narrow first");
    fetch(0, 10'h3FF, 0, "narrow R9 back-to-back top addr");
    fetch(0, 10'h0A7, 40, "narrow R8 req mid access");
    idle_check(0, 20, "narrow");
  endtask

  task automatic test_wide();
    fetch(1, 10'h123, 0, "wide first");
    fetch(1, 10'h2AA, 3, "wide R8 req early");
    idle_check(1, 20, "wide");
  endtask

  task automatic test_intlv();
    fetch(2, 10'h045, 0, "intlv first");
    fetch(2, 10'h3FF, 19, "intlv R8 req in last data cycle");
    idle_check(2, 20, "intlv");
    fetch(2, 10'h001, 0, "intlv after idle");
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      req_m[m]    = 1'b0;
      addr_m[m]   = '0;
      last_pen[m] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_narrow();
    test_wide();
    test_intlv();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule